// File: doc/BRIEF.md
# Split-Product Field Reduction Unit for GF(2^163)

This unit takes an unreduced carry-less product c(x) of two GF(2^163) elements. The product is 325 bits wide, with degree at most 324. The unit prepares c(x) for a reduction that finishes in a residue-domain multiplier.

The bits of c at degree 163 and above form a high polynomial. That high polynomial is shifted up to degree 163 and reduced modulo f(x) = x^163 + x^7 + x^6 + x^3 + 1, which gives a 163-bit remainder c'. The unit then presents two 325-bit vectors:

- The first vector keeps the high bits of c and replaces the low 163 bits with c'.
- The second vector is c unchanged.

Because the high part appears in both vectors, it cancels when they are summed. The XOR of the two vectors is therefore c mod f, with every bit above degree 162 at zero. A consumer can convert both vectors to residue form and combine them with a plain XOR.

A direct 163-bit reduced value is also provided for checking. All results are built from XOR networks only. They are registered once, so they appear one clock after the product is presented.

Top module: `gf163_split_reduce`

## Requirements
- R1: While rst_n is low, split_a_o, split_b_o and red_o all read zero at every rising clock edge.
- R2: Each output reflects the value of prod_i sampled at the previous rising clock edge. A change on prod_i between edges does not alter the outputs before the next edge.
- R3: split_b_o equals the sampled product c, bit for bit.
- R4: Bits 324..163 of split_a_o equal bits 324..163 of the sampled c.
- R5: Bits 162..0 of split_a_o equal (c with bits 162..0 cleared) mod f(x), where f(x) = x^163 + x^7 + x^6 + x^3 + 1.
- R6: The XOR of split_a_o and split_b_o has all bits 324..163 at zero, and its bits 162..0 equal c mod f(x).
- R7: red_o equals c mod f(x).
- R8: When bits 324..163 of c are all zero, bits 162..0 of split_a_o are zero, and red_o equals bits 162..0 of c.
- R9: Products whose high part overflows past degree 162 after the first fold are still fully reduced. Examples are x^324, x^170 and the all-ones product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_i | input | 325 | Unreduced product c, bit k holds the coefficient of x^k |
| split_a_o | output | 325 | High bits of c above the reduced remainder c' |
| split_b_o | output | 325 | The product c passed through |
| red_o | output | 163 | c mod f(x) |

## Verification
The bench builds the unit with its default parameters: field degree 163 and the low-term mask 0xC9. With these values the fold reaches its widest case. The first pass spills six bits above degree 162, and the second pass must absorb them.

Hand-derived vectors pin down the single-term cases x^163, x^170 and x^324, as well as f(x) itself. Pseudo-random and all-ones products are compared against a bit-serial shift-and-subtract reduction written in the bench.

// File: rtl/gfsr_pkg.sv
package gfsr_pkg;

    // field degree
    localparam int FLD_M = 163;

    // terms of f(x) below x^FLD_M: x^7 + x^6 + x^3 + 1
    localparam logic [FLD_M-1:0] FLD_LOW = FLD_M'('hC9);

    // degree of the highest set bit of a low-term mask
    function automatic int low_degree(input logic [FLD_M-1:0] mask);
        int d;
        d = 0;
        for (int i = 0; i < FLD_M; i++) begin
            if (mask[i]) d = i;
        end
        return d;
    endfunction

endpackage

// File: rtl/gfsr_fold.sv
// One reduction pass: multiplies a high slice by the low terms of f(x),
// which is what x^M times that slice becomes modulo f(x).
module gfsr_fold #(
    parameter int          HW  = 8,
    parameter int          M   = 163,
    parameter int          GD  = 7,
    parameter logic [M-1:0] LOW = M'('hC9)
) (
    input  logic [HW-1:0]    hi_i,
    output logic [HW+GD-1:0] fold_o
);

    localparam int OW = HW + GD;

    logic [OW-1:0] acc;

    always_comb begin
        acc = '0;
        for (int t = 0; t <= GD; t++) begin
            if (LOW[t]) acc = acc ^ (OW'(hi_i) << t);
        end
    end

    assign fold_o = acc;

endmodule

// File: rtl/gfsr_split.sv
// Computes c' = (c_hi * x^M) mod f(x) with one or two XOR folds.
module gfsr_split #(
    parameter int           M   = 163,
    parameter logic [M-1:0] LOW = M'('hC9),
    parameter int           GD  = 7
) (
    input  logic [M-2:0] hi_i,
    output logic [M-1:0] rem_o
);

    localparam int W1 = (M - 1) + GD;   // width after first fold
    localparam int S1 = W1 - M;         // bits spilling above degree M-1

    logic [W1-1:0] f1;

    gfsr_fold #(.HW(M-1), .M(M), .GD(GD), .LOW(LOW)) u_pass1 (
        .hi_i   (hi_i),
        .fold_o (f1)
    );

    generate
        if (S1 > 0) begin : g_two_pass
            localparam int W2 = S1 + GD;
            logic [W2-1:0] f2;

            gfsr_fold #(.HW(S1), .M(M), .GD(GD), .LOW(LOW)) u_pass2 (
                .hi_i   (f1[W1-1:M]),
                .fold_o (f2)
            );

            assign rem_o = f1[M-1:0] ^ M'(f2);
        end else begin : g_one_pass
            assign rem_o = M'(f1);
        end
    endgenerate

endmodule

// File: rtl/gf163_split_reduce.sv
module gf163_split_reduce #(
    parameter int           M   = gfsr_pkg::FLD_M,
    parameter logic [M-1:0] LOW = gfsr_pkg::FLD_LOW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*M-2:0] prod_i,
    output logic [2*M-2:0] split_a_o,
    output logic [2*M-2:0] split_b_o,
    output logic [M-1:0]   red_o
);

    localparam int PW = 2 * M - 1;
    localparam int GD = gfsr_pkg::low_degree(LOW);

    typedef struct packed {
        logic [PW-1:0] split_a;
        logic [PW-1:0] split_b;
        logic [M-1:0]  red;
    } out_t;

    out_t          st_d, st_q;
    logic [M-1:0]  crem;

    gfsr_split #(.M(M), .LOW(LOW), .GD(GD)) u_split (
        .hi_i  (prod_i[PW-1:M]),
        .rem_o (crem)
    );

    always_comb begin
        st_d         = st_q;
        st_d.split_a = {prod_i[PW-1:M], crem};
        st_d.split_b = prod_i;
        st_d.red     = crem ^ prod_i[M-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign split_a_o = st_q.split_a;
    assign split_b_o = st_q.split_b;
    assign red_o     = st_q.red;

endmodule

// File: rtl/gf163_split_reduce_chk.sv
module gf163_split_reduce_chk #(
    parameter int M = 163
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2*M-2:0] prod_i,
    input logic [2*M-2:0] split_a_o,
    input logic [2*M-2:0] split_b_o,
    input logic [M-1:0]   red_o
);

    logic [2*M-2:0] sum_w;
    logic           vld_q;

    assign sum_w = split_a_o ^ split_b_o;

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (split_a_o == '0 && split_b_o == '0 && red_o == '0));

    // R3
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> split_b_o == $past(prod_i));

    // R4
    high_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_a_o[2*M-2:M] == split_b_o[2*M-2:M]);

    // R6
    upper_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_w[2*M-2:M] == '0);

    // R7
    direct_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        red_o == sum_w[M-1:0]);

    // R8
    no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && $past(prod_i[2*M-2:M]) == '0) |->
        (split_a_o[M-1:0] == '0 && red_o == $past(prod_i[M-1:0])));

endmodule

bind gf163_split_reduce gf163_split_reduce_chk #(.M(M)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prod_i    (prod_i),
    .split_a_o (split_a_o),
    .split_b_o (split_b_o),
    .red_o     (red_o)
);

// File: tb/gf163_split_reduce_bench.sv
`timescale 1ns/1ps
module gf163_split_reduce_bench;

    localparam int M  = 163;
    localparam int PW = 2 * M - 1;
    localparam logic [PW-1:0] FPOLY = (PW'(1) << M) | PW'('hC9);
    localparam int NV = 6;

    localparam logic [PW-1:0] TV_IN [NV] = '{
        PW'(0),
        PW'(1) << M,
        PW'(1) << (PW - 1),
        PW'(1) << 170,
        PW'('hABCD),
        (PW'(1) << M) | PW'('hC9)
    };
    localparam logic [M-1:0] TV_EXP [NV] = '{
        M'(0),
        M'('hC9),
        (M'(1) << 161) | M'('h1422),
        M'('h6480),
        M'('hABCD),
        M'(0)
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [PW-1:0]  prod_i = '0;
    logic [PW-1:0]  split_a_o, split_b_o;
    logic [M-1:0]   red_o;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

    always #2.5 clk = ~clk;

    gf163_split_reduce u_gf163_split_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .prod_i    (prod_i),
        .split_a_o (split_a_o),
        .split_b_o (split_b_o),
        .red_o     (red_o)
    );

    function automatic logic [M-1:0] ref_mod(input logic [PW-1:0] c);
        logic [PW-1:0] r;
        r = c;
        for (int i = PW - 1; i >= M; i--) begin
            if (r[i]) r = r ^ (FPOLY << (i - M));
        end
        return r[M-1:0];
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [PW-1:0] v);
        @(negedge clk);
        prod_i = v;
        @(negedge clk);
    endtask

    task automatic check_all(input logic [PW-1:0] c, input logic [M-1:0] expm);
        logic [PW-1:0] sum;
        logic [PW-1:0] hi_only;
        sum     = split_a_o ^ split_b_o;
        hi_only = c & ~PW'({M{1'b1}});
        check("R3 pass-through", split_b_o, c);
        check("R4 high bits", PW'(split_a_o[PW-1:M]), PW'(c[PW-1:M]));
        check("R5 remainder", PW'(split_a_o[M-1:0]), PW'(ref_mod(hi_only)));
        check("R6 upper zero", PW'(sum[PW-1:M]), '0);
        check("R6 sum low", PW'(sum[M-1:0]), PW'(expm));
        check("R7 direct", PW'(red_o), PW'(expm));
    endtask

    function automatic logic [63:0] xs(input logic [63:0] s);
        logic [63:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with a live input
        prod_i = {PW{1'b1}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset a", split_a_o, '0);
        check("R1 reset b", split_b_o, '0);
        check("R1 reset red", PW'(red_o), '0);
        rst_n = 1'b1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            apply(TV_IN[k]);
            check("R7 table vs hand value", PW'(TV_EXP[k]), PW'(ref_mod(TV_IN[k])));
            check_all(TV_IN[k], TV_EXP[k]);
        end

        // R9: overflowing high parts
        apply({PW{1'b1}});
        check_all({PW{1'b1}}, ref_mod({PW{1'b1}}));
        check("R9 all ones", PW'(red_o), PW'(ref_mod({PW{1'b1}})));
        apply(PW'(1) << (PW - 1));
        check("R9 top term", PW'(red_o), PW'(TV_EXP[2]));

        // R8: empty high part
        apply(PW'({M{1'b1}}));
        check("R8 rem zero", PW'(split_a_o[M-1:0]), '0);
        check("R8 direct low", PW'(red_o), PW'({M{1'b1}}));

        // R2: input change between edges does not move the outputs
        apply(PW'('h1234) << 200);
        @(negedge clk);
        prod_i = PW'('h55);
        #1;
        check("R2 hold b", split_b_o, PW'('h1234) << 200);
        @(negedge clk);
        check("R2 update b", split_b_o, PW'('h55));

        // pseudo-random products
        for (int n = 0; n < 40; n++) begin
            logic [PW-1:0] v;
            v = '0;
            for (int w = 0; w < 6; w++) begin
                rs = xs(rs);
                v = (v << 64) | PW'(rs);
            end
            apply(v);
            check_all(v, ref_mod(v));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule